// File: doc/BRIEF.md
# BCD Calendar Counter

This block keeps wall-clock time and the calendar date as seven packed-BCD bytes: seconds, minutes, hours, day of week, day of month, month and two-digit year. Each one-cycle strobe on the tick input advances the time by one second. The carry runs through the seconds, minutes and hours, then into the day of week and the day of month together, then into the month and the year. The block knows how long each month is. It picks the leap year from the two BCD year digits alone and does no binary arithmetic on them. Time is kept in 24-hour form.

A serial host port sits next to the block. It writes all seven bytes at once through a parallel load and reads them back from the outputs as a snapshot. While a host write is in progress it raises the halt input so that no second is counted. Some bytes carry spare upper bits: a supply-flag bit above the seconds, a frequency-select bit above the weekday and a test bit above the month. The counter keeps these bits exactly as they were loaded.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the seconds, minutes and hours read 8'h00, the weekday reads 8'h01, the day of month reads 8'h01, the month reads 8'h01 and the year reads 8'h00.
- R2: The seconds count 00 to 59 in BCD and go from 59 to 00, advancing the minutes. The minutes count 00 to 59 the same way and go from 59 to 00, advancing the hours. Each accepted tick adds exactly one second.
- R3: The hours count 00 to 23. The step from 23 to 00 advances the day of month and the weekday by one in the same cycle.
- R4: The weekday uses bits [2:0], counts 1 to 7 and wraps from 7 to 1.
- R5: The last day is 30 for months 8'h04, 8'h06, 8'h09 and 8'h11, and 31 for every other month except February (8'h02). Stepping past the last day gives day 8'h01 of the next month.
- R6: February ends on day 28, or on day 29 in a leap year. A year is a leap year when its tens digit is odd and its units digit is 2 or 6, or when its tens digit is even and its units digit is 0, 4 or 8.
- R7: Month 12 goes to 01 and advances the year. Year 99 goes to 00 and nothing else changes.
- R8: A tick that arrives while halt is high changes no output. Counting starts again with the first tick after halt goes low.
- R9: A load puts all seven load bytes on the outputs one cycle later. A load wins over a tick in the same cycle, and it also takes effect while halt is high.
- R10: Counting never changes the bits above the count field. Those bits are seconds bit 7, minutes bit 7, hours bits 7:6, weekday bits 7:3, day bits 7:6 and month bits 7:5. They keep the value they were loaded with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| halt_i | input | 1 | Blocks tick increments while high |
| load_i | input | 1 | Parallel load of all fields |
| ld_sec_i | input | 8 | Seconds byte to load |
| ld_min_i | input | 8 | Minutes byte to load |
| ld_hour_i | input | 8 | Hours byte to load |
| ld_wday_i | input | 8 | Weekday byte to load |
| ld_mday_i | input | 8 | Day-of-month byte to load |
| ld_mon_i | input | 8 | Month byte to load |
| ld_year_i | input | 8 | Year byte to load |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Weekday byte |
| mday_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Year byte |

## Verification
The bench runs a full day of ticks, one tick per cycle. This finds a BCD digit step that goes to 0A, and a seconds, minutes or hours field that wraps at the wrong count or fails to carry. For every month of all hundred years it loads the day before the month end and then the last day, each at 23:59:59, and ticks once. A wrong month length or a wrong leap-digit rule shows up as a day 29, 30 or 31 where 01 is expected, or the other way round. The same sweep exercises the weekday wrap, the December rollover into the next year and the step from year 99 to 00, and it sets the spare upper bits on alternate cases to catch a counter that clears them. Separate tests tick while halt is high, where a broken design would move, and raise tick together with load, where a broken design would add one second to the loaded time.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Add one to a two-digit packed BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Leap test from the two year digits: parity of tens, value of units
  function automatic logic leap_from_digits(input logic [7:0] y);
    logic [3:0] u;
    u = y[3:0];
    if (y[4]) leap_from_digits = (u == 4'd2) || (u == 4'd6);
    else      leap_from_digits = (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
  endfunction

  // Last day of a month, in BCD
  function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      month_last = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [7:0] mon_cnt_i,
  input  logic [7:0] year_i,
  output logic       leap_o,
  output logic [7:0] last_day_o
);

  always_comb begin
    leap_o     = leap_from_digits(year_i);
    last_day_o = month_last(mon_cnt_i, leap_o);
  end

endmodule

// File: rtl/cal_wrap_cnt.sv
module cal_wrap_cnt
  import cal_pkg::*;
#(
  parameter logic [7:0] CNT_MASK = 8'h7F,
  parameter logic [7:0] RST_VAL  = 8'h00,
  parameter logic [7:0] FIRST    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       step_i,
  input  logic [7:0] last_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);

  localparam logic [7:0] KEEP_MASK = ~CNT_MASK;

  logic [7:0] val_q;
  logic [7:0] cnt;
  logic       at_last;

  assign cnt     = val_q & CNT_MASK;
  assign at_last = (cnt == last_i);
  assign wrap_o  = step_i & at_last;
  assign val_o   = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      val_q <= RST_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (step_i) val_q <= (val_q & KEEP_MASK) |
                              ((at_last ? FIRST : bcd_inc(cnt)) & CNT_MASK);
  end

  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ((val_q & KEEP_MASK) == $past(val_q & KEEP_MASK)));

  // R2
  digit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt[3:0] <= 4'd9) |=> (cnt[3:0] <= 4'd9));

  // R4
  wrap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !load_i) |=> (cnt == FIRST));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(val_q));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       halt_i,
  input  logic       load_i,
  input  logic [7:0] ld_sec_i,
  input  logic [7:0] ld_min_i,
  input  logic [7:0] ld_hour_i,
  input  logic [7:0] ld_wday_i,
  input  logic [7:0] ld_mday_i,
  input  logic [7:0] ld_mon_i,
  input  logic [7:0] ld_year_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);

  localparam logic [7:0] SEC_MASK  = 8'h7F;
  localparam logic [7:0] MIN_MASK  = 8'h7F;
  localparam logic [7:0] HOUR_MASK = 8'h3F;
  localparam logic [7:0] WDAY_MASK = 8'h07;
  localparam logic [7:0] MDAY_MASK = 8'h3F;
  localparam logic [7:0] MON_MASK  = 8'h1F;
  localparam logic [7:0] YEAR_MASK = 8'hFF;

  // Named internal events
  logic       sec_step;
  logic       sec_wrap, min_wrap, hour_wrap, wday_wrap, mday_wrap, mon_wrap, year_wrap;
  logic       leap_year;
  logic [7:0] mday_last;

  assign sec_step = tick_i & ~halt_i & ~load_i;

  cal_month_len u_len (
    .mon_cnt_i (mon_o & MON_MASK),
    .year_i    (year_o),
    .leap_o    (leap_year),
    .last_day_o(mday_last)
  );

  cal_wrap_cnt #(.CNT_MASK(SEC_MASK), .RST_VAL(8'h00), .FIRST(8'h00)) u_sec (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_sec_i),
    .step_i(sec_step), .last_i(8'h59), .val_o(sec_o), .wrap_o(sec_wrap));

  cal_wrap_cnt #(.CNT_MASK(MIN_MASK), .RST_VAL(8'h00), .FIRST(8'h00)) u_min (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_min_i),
    .step_i(sec_wrap), .last_i(8'h59), .val_o(min_o), .wrap_o(min_wrap));

  cal_wrap_cnt #(.CNT_MASK(HOUR_MASK), .RST_VAL(8'h00), .FIRST(8'h00)) u_hour (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_hour_i),
    .step_i(min_wrap), .last_i(8'h23), .val_o(hour_o), .wrap_o(hour_wrap));

  cal_wrap_cnt #(.CNT_MASK(WDAY_MASK), .RST_VAL(8'h01), .FIRST(8'h01)) u_wday (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_wday_i),
    .step_i(hour_wrap), .last_i(8'h07), .val_o(wday_o), .wrap_o(wday_wrap));

  cal_wrap_cnt #(.CNT_MASK(MDAY_MASK), .RST_VAL(8'h01), .FIRST(8'h01)) u_mday (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_mday_i),
    .step_i(hour_wrap), .last_i(mday_last), .val_o(mday_o), .wrap_o(mday_wrap));

  cal_wrap_cnt #(.CNT_MASK(MON_MASK), .RST_VAL(8'h01), .FIRST(8'h01)) u_mon (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_mon_i),
    .step_i(mday_wrap), .last_i(8'h12), .val_o(mon_o), .wrap_o(mon_wrap));

  cal_wrap_cnt #(.CNT_MASK(YEAR_MASK), .RST_VAL(8'h00), .FIRST(8'h00)) u_year (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(ld_year_i),
    .step_i(mon_wrap), .last_i(8'h99), .val_o(year_o), .wrap_o(year_wrap));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !load_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o)));

  // R9
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sec_o == $past(ld_sec_i) && min_o == $past(ld_min_i) &&
      hour_o == $past(ld_hour_i) && wday_o == $past(ld_wday_i) &&
      mday_o == $past(ld_mday_i) && mon_o == $past(ld_mon_i) &&
      year_o == $past(ld_year_i)));

  // R3
  day_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($changed(wday_o) == $changed(mday_o)));

  // R7
  year_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> (year_o == 8'h00 && mon_o[4:0] == 5'h01));

endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, halt = 1'b0, load = 1'b0;
  logic [7:0] l_sec = 0, l_min = 0, l_hour = 0, l_wday = 0, l_mday = 0, l_mon = 0, l_year = 0;
  logic [7:0] sec, mins, hour, wday, mday, mon, year;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .halt_i(halt), .load_i(load),
    .ld_sec_i(l_sec), .ld_min_i(l_min), .ld_hour_i(l_hour), .ld_wday_i(l_wday),
    .ld_mday_i(l_mday), .ld_mon_i(l_mon), .ld_year_i(l_year),
    .sec_o(sec), .min_o(mins), .hour_o(hour), .wday_o(wday), .mday_o(mday),
    .mon_o(mon), .year_o(year));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int y, input int m);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] s, mi, h, w, d, mo, y, input logic with_tick);
    @(negedge clk);
    load = 1'b1; tick = with_tick;
    l_sec = s; l_min = mi; l_hour = h; l_wday = w; l_mday = d; l_mon = mo; l_year = y;
    @(negedge clk);
    load = 1'b0; tick = 1'b0;
  endtask

  task automatic one_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset time", {8'h0, hour, mins, sec}, 32'h0);
    chk("R1", "reset date", {wday, mday, mon, year}, 32'h01010100);

    // R2 R3 full day, one tick per cycle
    @(negedge clk);
    tick = 1'b1;
    for (int t = 1; t <= 86400; t++) begin
      int tt;
      @(negedge clk);
      tt = t % 86400;
      chk("R2", "hms", {8'h0, hour, mins, sec},
          {8'h0, to_bcd(tt / 3600), to_bcd((tt / 60) % 60), to_bcd(tt % 60)});
    end
    tick = 1'b0;
    chk("R3", "day after midnight", {wday, mday}, 16'h0202);

    // R4 R5 R6 R7 R10 month-end sweep over all years
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int last, w, ny, nm;
        logic fl;
        last = days_in(y, m);
        w = (m % 7) + 1;
        fl = ((y + m) % 2) == 1;
        do_load(8'h59, 8'h59, 8'h23, to_bcd(w), to_bcd(last - 1), to_bcd(m), to_bcd(y), 1'b0);
        one_tick();
        chk("R5", "day before end", {mday, mon}, {to_bcd(last), to_bcd(m)});
        do_load(fl ? 8'hD9 : 8'h59, 8'h59, fl ? 8'hE3 : 8'h23,
                to_bcd(w) | (fl ? 8'h08 : 8'h00), to_bcd(last),
                to_bcd(m) | (fl ? 8'h80 : 8'h00), to_bcd(y), 1'b0);
        one_tick();
        nm = (m == 12) ? 1 : m + 1;
        ny = (m == 12) ? (y + 1) % 100 : y;
        chk("R6", "roll to next month", {mday, mon & 8'h1F, year},
            {8'h01, to_bcd(nm), to_bcd(ny)});
        chk("R7", "year and month", {mon & 8'h1F, year}, {to_bcd(nm), to_bcd(ny)});
        chk("R4", "weekday", wday & 8'h07, (w % 7) + 1);
        chk("R10", "flags kept", {sec, hour, wday & 8'hF8, mon & 8'hE0},
            fl ? 32'h80C00880 : 32'h0);
      end
    end

    // R8 halt suppresses ticks
    do_load(8'h10, 8'h20, 8'h05, 8'h03, 8'h15, 8'h06, 8'h24, 1'b0);
    @(negedge clk);
    halt = 1'b1;
    tick = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8", "frozen while halted", {hour, mins, sec, mday}, 32'h05201015);
    tick = 1'b0;
    halt = 1'b0;
    one_tick();
    chk("R8", "resumes after halt", {hour, mins, sec}, 24'h052011);

    // R9 load wins over tick; load during halt
    do_load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 1'b1);
    chk("R9", "load over tick", {hour, mins, sec, year}, 32'h23595999);
    @(negedge clk);
    halt = 1'b1;
    do_load(8'h30, 8'h40, 8'h12, 8'h02, 8'h10, 8'h03, 8'h50, 1'b0);
    chk("R9", "load during halt", {hour, mins, sec, mon}, 32'h12403003);
    halt = 1'b0;

    // R7 year 99 wraps to 00
    do_load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 1'b0);
    one_tick();
    chk("R7", "century wrap", {wday, mday, mon, year}, 32'h01010100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule